// File: doc/BRIEF.md
# Device Mailbox Register Window

This block is the host-facing register window of a command mailbox in a memory-expansion device. The host reaches it with naturally aligned reads and writes of 1, 2, 4 or 8 bytes. The window holds five registers and a byte-addressable payload buffer:

- a 32-bit capability word;
- a 32-bit control word whose bit 0 is the doorbell;
- a 64-bit command word;
- a 64-bit status word;
- a 64-bit background-status word.

Each register has its own write policy, and that policy depends on both the offset and the access width.

When a host write below the payload area leaves the doorbell at 1, the block sends a single start pulse to an external command engine. It then holds a busy flag until the engine reports completion. Completion comes through a side port that loads the status word and drops the doorbell.

Every access that is illegal, or that the window refuses, sets a sticky error flag. The bus never stalls.

Byte map (little-endian):

| Offset | Register |
|---|---|
| 0x00 | capability |
| 0x04 | control |
| 0x08 | command |
| 0x10 | status |
| 0x18 | background status |
| 0x20 onward | payload, `PAYLOAD_BYTES` bytes |

Top module: `mbx_window`

## Requirements
- R1: An access whose address is not a multiple of its size, or whose payload word lies past the end of the buffer, changes no storage and sets the error flag. A read of that kind returns zero.
- R2: A read returns, one cycle after `bus_rd`, the bytes at that offset in little-endian order in the low bytes of `bus_rdata`. The upper bytes are zero. `bus_rvalid` is high in that cycle.
- R3: A write at offset 0x20 or above, of any size, stores exactly its bytes into the payload and never produces a start pulse.
- R4: Below offset 0x20, a 4-byte write takes effect only at 0x00 (capability bits 31:7) or 0x04 (control). Any other 4-byte write there is dropped and sets the error flag.
- R5: Below offset 0x20, an 8-byte write takes effect only at 0x08 (command). 8-byte writes to status (0x10) or background status (0x18) are dropped and set the error flag.
- R6: Below offset 0x20, 1-byte and 2-byte writes change no register and set the error flag.
- R7: In the cycle after any write below the payload area, if the doorbell (control bit 0) is 1 and the block is not busy, `cmd_start` is high for exactly one cycle. `cmd_busy` rises in the following cycle.
- R8: While busy, no further start pulse is issued, and a host write to control cannot clear the doorbell.
- R9: A `cmd_done` pulse while busy loads `cmd_status` into the status word, clears the doorbell and drops `cmd_busy` on the next cycle.
- R10: Capability bits 4:0 read as log2 of the payload size (11 for 2048 bytes). Bit 5 (interrupt support) and bit 6 (background support) read as 0.
- R11: Reset clears control, command, status, the capability spare bits, the whole payload, busy and the error flag.
- R12: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte offset in the window |
| bus_size | input | 2 | Access size: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| bus_wdata | input | 64 | Write data, low bytes used |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| cmd_start | output | 1 | One-cycle request to the command engine |
| cmd_busy | output | 1 | A command is outstanding |
| cmd_value | output | 64 | Current command word |
| cmd_done | input | 1 | Engine completion pulse |
| cmd_status | input | 64 | Status written on completion |
| acc_err | output | 1 | Sticky illegal-access flag |

## Verification
The hardest state to reach from the ports is a host write to control that arrives while a command is outstanding. That write must neither clear the doorbell nor raise a second request. To reach it, the stimulus rings the doorbell, waits for busy, and then writes control both with 0 and with 1. It reads control back and watches `cmd_start` in each following cycle before it pulses completion.

Dropped writes are proven only by reading back the register they aimed at. Error-flag checks are separated by resets, because the flag is sticky.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned OFF_CAP     = 0;
    localparam int unsigned OFF_CTRL    = 4;
    localparam int unsigned OFF_CMD     = 8;
    localparam int unsigned OFF_STS     = 16;
    localparam int unsigned OFF_BGSTS   = 24;
    localparam int unsigned OFF_PAYLOAD = 32;
    localparam int unsigned REG_WORDS   = OFF_PAYLOAD / 8;

    localparam int unsigned CAP_EXP_W   = 5;
    localparam int unsigned CAP_FIXED_W = 7;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_PAYLOAD,
        WK_CAP,
        WK_CTRL,
        WK_CMD,
        WK_DROP
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e   kind;
        logic       fault;
        logic       in_pay;
        logic [2:0] off;
        logic [7:0] be;
    } acc_info_t;

    function automatic logic [7:0] size_lanes(acc_size_e sz);
        case (sz)
            SZ_B1:   return 8'h01;
            SZ_B2:   return 8'h03;
            SZ_B4:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [2:0] align_bits(acc_size_e sz);
        case (sz)
            SZ_B1:   return 3'd0;
            SZ_B2:   return 3'd1;
            SZ_B4:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [63:0] lanes_to_bits(logic [7:0] lanes);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) begin
            m[8*i +: 8] = {8{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PAY_WORDS = 256,
    parameter int unsigned PAY_IDX_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  acc_size_e            size,
    input  logic                 is_wr,
    output acc_info_t            info,
    output logic [ADDR_W-4:0]    word_idx,
    output logic [PAY_IDX_W-1:0] pay_idx
);

    localparam int unsigned WIDX_W = ADDR_W - 3;

    logic [WIDX_W-1:0] pay_full;
    logic              misalign;
    logic              beyond;

    always_comb begin
        word_idx = addr[ADDR_W-1:3];
        pay_full = word_idx - WIDX_W'(REG_WORDS);
        pay_idx  = pay_full[PAY_IDX_W-1:0];

        info.off    = addr[2:0];
        info.be     = size_lanes(size) << addr[2:0];
        info.in_pay = (addr >= ADDR_W'(OFF_PAYLOAD));

        misalign   = |(addr[2:0] & align_bits(size));
        beyond     = info.in_pay && (32'(pay_full) >= PAY_WORDS);
        info.fault = misalign || beyond;

        if (!is_wr) begin
            info.kind = WK_NONE;
        end else if (info.fault) begin
            info.kind = WK_DROP;
        end else if (info.in_pay) begin
            info.kind = WK_PAYLOAD;
        end else if (size == SZ_B4 && addr == ADDR_W'(OFF_CAP)) begin
            info.kind = WK_CAP;
        end else if (size == SZ_B4 && addr == ADDR_W'(OFF_CTRL)) begin
            info.kind = WK_CTRL;
        end else if (size == SZ_B8 && addr == ADDR_W'(OFF_CMD)) begin
            info.kind = WK_CMD;
        end else begin
            info.kind = WK_DROP;
        end
    end

endmodule

// File: rtl/mbx_payload.sv
module mbx_payload #(
    parameter int unsigned WORDS = 256,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       be,
    input  logic [63:0]      wdata,
    output logic [63:0]      rdata
);

    for (genvar b = 0; b < 8; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < int'(WORDS); w++) begin
                    lane_mem[w] <= 8'h00;
                end
            end else if (we && be[b]) begin
                lane_mem[idx] <= wdata[8*b +: 8];
            end
        end

        assign rdata[8*b +: 8] = lane_mem[idx];
    end

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell (
    input  logic clk,
    input  logic rst,
    input  logic poke,
    input  logic ring,
    input  logic done,
    output logic start,
    output logic busy,
    output logic finish
);

    logic chk_q;
    logic busy_q;

    assign start  = chk_q && ring && !busy_q;
    assign busy   = busy_q;
    assign finish = done && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            chk_q <= poke;
            if (start) begin
                busy_q <= 1'b1;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mbx_window.sv
module mbx_window
    import mbx_pkg::*;
#(
    parameter int unsigned PAYLOAD_BYTES = 2048,
    localparam int unsigned PAY_WORDS    = PAYLOAD_BYTES / 8,
    localparam int unsigned PAY_IDX_W    = $clog2(PAY_WORDS),
    localparam int unsigned ADDR_W       = $clog2(OFF_PAYLOAD + PAYLOAD_BYTES),
    localparam int unsigned CAP_EXP      = $clog2(PAYLOAD_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              cmd_start,
    output logic              cmd_busy,
    output logic [63:0]       cmd_value,
    input  logic              cmd_done,
    input  logic [63:0]       cmd_status,
    output logic              acc_err
);

    localparam int unsigned WIDX_W = ADDR_W - 3;

    acc_size_e              sz;
    acc_info_t              info;
    logic [WIDX_W-1:0]      word_idx;
    logic [PAY_IDX_W-1:0]   pay_idx;
    logic [63:0]            pay_rdata;
    logic [63:0]            pay_wdata;
    logic                   pay_wr_en;
    logic                   poke;
    logic                   finish;

    logic [31:CAP_FIXED_W]  cap_hi_q;
    logic [31:0]            ctrl_q;
    logic [63:0]            cmd_q;
    logic [63:0]            sts_q;
    logic [63:0]            bgsts;
    logic [31:0]            cap_word;
    logic [63:0]            word_sel;
    logic [63:0]            rd_next;

    assign sz = acc_size_e'(bus_size);

    mbx_decode #(
        .ADDR_W   (ADDR_W),
        .PAY_WORDS(PAY_WORDS),
        .PAY_IDX_W(PAY_IDX_W)
    ) u_decode (
        .addr    (bus_addr),
        .size    (sz),
        .is_wr   (bus_wr),
        .info    (info),
        .word_idx(word_idx),
        .pay_idx (pay_idx)
    );

    assign pay_wr_en = (info.kind == WK_PAYLOAD);
    assign pay_wdata = bus_wdata << {info.off, 3'b000};
    assign poke      = bus_wr && !pay_wr_en;

    mbx_payload #(
        .WORDS(PAY_WORDS),
        .IDX_W(PAY_IDX_W)
    ) u_payload (
        .clk  (clk),
        .rst  (rst),
        .we   (pay_wr_en),
        .idx  (pay_idx),
        .be   (info.be),
        .wdata(pay_wdata),
        .rdata(pay_rdata)
    );

    mbx_doorbell u_doorbell (
        .clk   (clk),
        .rst   (rst),
        .poke  (poke),
        .ring  (ctrl_q[0]),
        .done  (cmd_done),
        .start (cmd_start),
        .busy  (cmd_busy),
        .finish(finish)
    );

    // Background commands are not offered: the word is fixed at zero.
    assign bgsts     = '0;
    assign cap_word  = {cap_hi_q, 1'b0, 1'b0, CAP_EXP_W'(CAP_EXP)};
    assign cmd_value = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_hi_q <= '0;
            ctrl_q   <= '0;
            cmd_q    <= '0;
            sts_q    <= '0;
            acc_err  <= 1'b0;
        end else begin
            case (info.kind)
                WK_CAP:  cap_hi_q <= bus_wdata[31:CAP_FIXED_W];
                WK_CTRL: ctrl_q   <= {bus_wdata[31:1], bus_wdata[0] | cmd_busy};
                WK_CMD:  cmd_q    <= bus_wdata;
                default: ;
            endcase
            if (finish) begin
                ctrl_q[0] <= 1'b0;
                sts_q     <= cmd_status;
            end
            if (info.kind == WK_DROP || (bus_rd && info.fault)) begin
                acc_err <= 1'b1;
            end
        end
    end

    always_comb begin
        case (word_idx)
            WIDX_W'(0): word_sel = {ctrl_q, cap_word};
            WIDX_W'(1): word_sel = cmd_q;
            WIDX_W'(2): word_sel = sts_q;
            WIDX_W'(3): word_sel = bgsts;
            default:    word_sel = pay_rdata;
        endcase
        rd_next = (word_sel >> {info.off, 3'b000}) & lanes_to_bits(size_lanes(sz));
        if (info.fault) begin
            rd_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_next : '0;
        end
    end

endmodule

// File: rtl/mbx_window_chk.sv
module mbx_window_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              pay_wr,
    input logic              cmd_start,
    input logic              cmd_busy,
    input logic              cmd_done,
    input logic              acc_err,
    input logic              ring,
    input logic [63:0]       sts
);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start);

    p_start_after_reg_write_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(bus_wr && !pay_wr));

    p_payload_no_ring_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && pay_wr) |=> !cmd_start);

    p_busy_keeps_ring_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_busy |-> ring);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_busy |-> !cmd_start);

    p_finish_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && cmd_busy) |=> (!cmd_busy && !ring));

    p_sts_only_engine_r5: assert property (@(posedge clk) disable iff (rst)
        !(cmd_done && cmd_busy) |=> $stable(sts));

    p_small_write_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size < 2'd2 && bus_addr < ADDR_W'(32)) |=> acc_err);

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        acc_err |=> acc_err);

endmodule

bind mbx_window mbx_window_chk #(.ADDR_W(ADDR_W)) u_mbx_window_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .pay_wr   (pay_wr_en),
    .cmd_start(cmd_start),
    .cmd_busy (cmd_busy),
    .cmd_done (cmd_done),
    .acc_err  (acc_err),
    .ring     (ctrl_q[0]),
    .sts      (sts_q)
);

// File: tb/test_mbx_window.sv
module test_mbx_window;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          bus_rvalid;
    logic          cmd_start;
    logic          cmd_busy;
    logic [63:0]   cmd_value;
    logic          cmd_done = 1'b0;
    logic [63:0]   cmd_status = '0;
    logic          acc_err;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    mbx_window i_mbx_window (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .cmd_start (cmd_start),
        .cmd_busy  (cmd_busy),
        .cmd_value (cmd_value),
        .cmd_done  (cmd_done),
        .cmd_status(cmd_status),
        .acc_err   (acc_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Write sampled at the next posedge; returns at the following negedge.
    task automatic do_wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = s;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        check("R2 rvalid", {63'd0, bus_rvalid}, 64'd1);
    endtask

    task automatic t_reset_state();
        logic [63:0] d;
        do_reset();
        check("R11 err", {63'd0, acc_err}, 64'd0);
        check("R11 busy", {63'd0, cmd_busy}, 64'd0);
        do_rd(12'h000, 2'd2, d); check("R10 cap", d, 64'h0000_000B);
        do_rd(12'h004, 2'd2, d); check("R11 ctrl", d, 64'd0);
        do_rd(12'h008, 2'd3, d); check("R11 cmd", d, 64'd0);
        do_rd(12'h010, 2'd3, d); check("R11 sts", d, 64'd0);
        do_rd(12'h818, 2'd3, d); check("R11 payload", d, 64'd0);
    endtask

    task automatic t_payload();
        logic [63:0] d;
        do_reset();
        do_wr(12'h020, 2'd3, 64'h1122_3344_5566_7788);
        check("R3 no start", {63'd0, cmd_start}, 64'd0);
        do_rd(12'h023, 2'd0, d); check("R2 byte", d, 64'h55);
        do_rd(12'h026, 2'd1, d); check("R2 half", d, 64'h1122);
        do_rd(12'h024, 2'd2, d); check("R2 word", d, 64'h1122_3344);
        do_wr(12'h021, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB);
        do_rd(12'h020, 2'd3, d); check("R3 byte merge", d, 64'h1122_3344_5566_AB88);
        do_wr(12'h02A, 2'd1, 64'h0000_0000_0000_BEEF);
        do_rd(12'h028, 2'd3, d); check("R3 half", d, 64'h0000_0000_BEEF_0000);
        do_wr(12'h81F, 2'd0, 64'h5A);
        do_rd(12'h81F, 2'd0, d); check("R3 last byte", d, 64'h5A);
        check("R3 no err", {63'd0, acc_err}, 64'd0);
    endtask

    task automatic t_reg_writes();
        logic [63:0] d;
        do_reset();
        do_wr(12'h004, 2'd2, 64'h0000_00F0);
        check("R7 no ring", {63'd0, cmd_start}, 64'd0);
        do_rd(12'h004, 2'd2, d); check("R4 ctrl", d, 64'h0000_00F0);
        do_wr(12'h000, 2'd2, 64'hFFFF_FFFF);
        do_rd(12'h000, 2'd2, d); check("R4 R10 cap", d, 64'hFFFF_FF8B);
        do_wr(12'h008, 2'd3, 64'hDEAD_BEEF_0123_4567);
        do_rd(12'h008, 2'd3, d); check("R5 cmd", d, 64'hDEAD_BEEF_0123_4567);
        check("R5 cmd_value", cmd_value, 64'hDEAD_BEEF_0123_4567);
        do_rd(12'h00A, 2'd0, d); check("R2 cmd byte", d, 64'h23);
        check("R4 no err", {63'd0, acc_err}, 64'd0);
    endtask

    task automatic t_dropped();
        logic [63:0] d;
        do_reset();
        do_wr(12'h010, 2'd2, 64'h1234_5678);
        do_rd(12'h010, 2'd3, d); check("R4 dropped 32b", d, 64'd0);
        check("R4 err", {63'd0, acc_err}, 64'd1);
        do_reset();
        do_wr(12'h010, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD);
        do_wr(12'h018, 2'd3, 64'h1111_2222_3333_4444);
        do_rd(12'h010, 2'd3, d); check("R5 sts", d, 64'd0);
        do_rd(12'h018, 2'd3, d); check("R5 bgsts", d, 64'd0);
        check("R5 err", {63'd0, acc_err}, 64'd1);
        do_reset();
        do_wr(12'h008, 2'd0, 64'h77);
        check("R6 err byte", {63'd0, acc_err}, 64'd1);
        do_wr(12'h004, 2'd1, 64'h0001);
        check("R6 no ring", {63'd0, cmd_start}, 64'd0);
        do_rd(12'h008, 2'd3, d); check("R6 cmd", d, 64'd0);
        do_rd(12'h004, 2'd2, d); check("R6 ctrl", d, 64'd0);
        repeat (3) @(negedge clk);
        check("R12 sticky", {63'd0, acc_err}, 64'd1);
    endtask

    task automatic t_fault();
        logic [63:0] d;
        do_reset();
        do_wr(12'h020, 2'd3, 64'h0102_0304_0506_0708);
        check("R1 clean", {63'd0, acc_err}, 64'd0);
        do_wr(12'h022, 2'd2, 64'hFFFF_FFFF);
        check("R1 misalign err", {63'd0, acc_err}, 64'd1);
        do_rd(12'h020, 2'd3, d); check("R1 unchanged", d, 64'h0102_0304_0506_0708);
        do_rd(12'h024, 2'd3, d); check("R1 misaligned read", d, 64'd0);
        do_reset();
        do_wr(12'h820, 2'd0, 64'h99);
        check("R1 beyond err", {63'd0, acc_err}, 64'd1);
        do_rd(12'h820, 2'd0, d); check("R1 beyond read", d, 64'd0);
    endtask

    task automatic t_doorbell();
        logic [63:0] d;
        do_reset();
        do_wr(12'h004, 2'd2, 64'h1);
        check("R7 start", {63'd0, cmd_start}, 64'd1);
        check("R7 not yet busy", {63'd0, cmd_busy}, 64'd0);
        @(negedge clk);
        check("R7 pulse ends", {63'd0, cmd_start}, 64'd0);
        check("R7 busy", {63'd0, cmd_busy}, 64'd1);
        do_wr(12'h004, 2'd2, 64'h0);
        check("R8 no restart", {63'd0, cmd_start}, 64'd0);
        do_rd(12'h004, 2'd2, d); check("R8 ring held", d, 64'h1);
        do_wr(12'h004, 2'd2, 64'h1);
        check("R8 no second start", {63'd0, cmd_start}, 64'd0);
        @(negedge clk);
        cmd_done = 1'b1; cmd_status = 64'h0000_0000_0000_CAFE;
        @(negedge clk);
        cmd_done = 1'b0;
        check("R9 idle", {63'd0, cmd_busy}, 64'd0);
        do_rd(12'h004, 2'd2, d); check("R9 ring cleared", d, 64'd0);
        do_rd(12'h010, 2'd3, d); check("R9 status", d, 64'h0000_0000_0000_CAFE);
        do_wr(12'h008, 2'd3, 64'h5);
        check("R7 idle write", {63'd0, cmd_start}, 64'd0);
        do_wr(12'h004, 2'd2, 64'h1);
        check("R7 start again", {63'd0, cmd_start}, 64'd1);
        do_reset();
        check("R11 busy cleared", {63'd0, cmd_busy}, 64'd0);
        do_rd(12'h010, 2'd3, d); check("R11 status cleared", d, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset_state();
        t_payload();
        t_reg_writes();
        t_dropped();
        t_fault();
        t_doorbell();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule